// File: doc/BRIEF.md
# Widening Vector Multiply-Accumulate Unit

This execution unit serves one class of three-register vector instructions: each element of one half of two 128-bit sources is widened to twice its width and multiplied by the element in the same position of the other source. The widened product either becomes the result lane outright, or is added to or subtracted from the matching lane of a third 128-bit operand, the old destination value. The element width (8, 16 or 32 bits), signed or unsigned extension, the choice of lower or upper source half, and the accumulate mode all come from fields of a 32-bit instruction word that the unit decodes itself.

The surrounding pipeline reads the register file, presents the word and the three operands with a one-cycle strobe, and collects a registered result one clock later. Encodings that are not allocated raise an illegal flag. Allocated encodings that belong to other subclasses of the same instruction group raise a separate unsupported flag, so the pipeline can route them elsewhere.

Top module: `wmac_top`

## Requirements
- R1: The opcode sits at word bits 15:12. Opcode 8 adds the widened product to the destination lane, opcode 10 subtracts it, and opcode 12 returns the product alone. These three execute only when the size field (bits 23:22) is 0, 1 or 2.
- R2: The illegal flag is raised for opcode 8, 10 or 12 with size 3, for opcode 9, 11, 13 or 14 with U (bit 29) set, and for opcode 15 with any U.
- R3: The unsupported flag is raised for opcodes 0 to 7, and for opcodes 9, 11, 13 and 14 with U clear. The two flags are never both set. Whenever either flag is set, the result is all zeros.
- R4: With U clear, source elements are sign-extended before the multiply. With U set, they are zero-extended.
- R5: With Q (bit 30) clear, elements come from bits 63:0 of each source. With Q set, they come from bits 127:64.
- R6: Size 0 gives eight 8-bit elements and 16-bit result lanes, size 1 gives four 16-bit elements and 32-bit lanes, and size 2 gives two 32-bit elements and 64-bit lanes. Element i of the selected half pairs with result lane i, and all 128 result bits are written.
- R7: Accumulation wraps modulo the result lane width, with no saturation. No carry or borrow crosses into a neighbouring lane.
- R8: Result and flags appear on the clock edge after the edge that samples the input strobe. The output valid pulse lasts one cycle. Result and flags hold their values until the next strobe.
- R9: Synchronous active-high reset clears the output valid, the result and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: word and operands are valid this cycle |
| insn | input | 32 | Instruction word |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| acc_in | input | 128 | Old destination vector |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_result | output | 128 | Registered result vector |
| out_illegal | output | 1 | Word was an unallocated encoding |
| out_unsupported | output | 1 | Word is allocated but outside this subclass |

## Verification
The assertions check on every cycle that the valid pulse follows the strobe by exactly one edge, that the result holds between strobes, that the two flags are never set together, and that a flagged result is zero. They also check that opcode 15 and the low opcodes are classified correctly. Lane arithmetic cannot be checked this way: signed against unsigned extension, half selection, lane packing per size, and wrap without cross-lane carry are shown only by the bench. It sweeps every combination of opcode, U, Q and size against an arithmetic lane-by-lane reference, and adds directed patterns at the extension and wrap boundaries.

// File: rtl/wmac_pkg.sv
package wmac_pkg;
   localparam int INSN_W = 32;
   localparam logic [3:0] OP_MLA = 4'd8;
   localparam logic [3:0] OP_MLS = 4'd10;
   localparam logic [3:0] OP_MUL = 4'd12;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_ADD  = 2'd1,
      ACC_SUB  = 2'd2
   } acc_mode_e;

   typedef struct packed {
      logic      exec;
      logic      illegal;
      logic      unsupp;
      logic      is_signed;
      logic      upper;
      logic [1:0] size;
      acc_mode_e mode;
   } dec_t;
endpackage

// File: rtl/wmac_decode.sv
module wmac_decode
   import wmac_pkg::*;
(
   input  logic [3:0] opcode,
   input  logic       u_bit,
   input  logic       q_bit,
   input  logic [1:0] size,
   output dec_t       dec
);
   logic widen_op;
   logic u_only_op;

   always_comb begin
      widen_op  = (opcode == OP_MLA) || (opcode == OP_MLS) || (opcode == OP_MUL);
      u_only_op = (opcode == 4'd9) || (opcode == 4'd11) ||
                  (opcode == 4'd13) || (opcode == 4'd14);

      dec           = '0;
      dec.is_signed = ~u_bit;
      dec.upper     = q_bit;
      dec.size      = size;
      dec.mode      = ACC_NONE;

      if (opcode == 4'd15) begin
         dec.illegal = 1'b1;
      end else if (widen_op) begin
         if (size == 2'd3) dec.illegal = 1'b1;
         else              dec.exec    = 1'b1;
      end else if (u_only_op) begin
         if (u_bit) dec.illegal = 1'b1;
         else       dec.unsupp  = 1'b1;
      end else begin
         dec.unsupp = 1'b1;
      end

      unique case (opcode)
         OP_MLA:  dec.mode = ACC_ADD;
         OP_MLS:  dec.mode = ACC_SUB;
         default: dec.mode = ACC_NONE;
      endcase
   end
endmodule

// File: rtl/wmac_lane.sv
module wmac_lane
   import wmac_pkg::*;
#(
   parameter int SRC_W = 8,
   localparam int DST_W = 2 * SRC_W
)(
   input  logic [SRC_W-1:0] a,
   input  logic [SRC_W-1:0] b,
   input  logic [DST_W-1:0] acc,
   input  logic             is_signed,
   input  acc_mode_e        mode,
   output logic [DST_W-1:0] res
);
   logic [DST_W-1:0] ext_a;
   logic [DST_W-1:0] ext_b;
   logic [DST_W-1:0] prod;

   always_comb begin
      ext_a = {{SRC_W{is_signed & a[SRC_W-1]}}, a};
      ext_b = {{SRC_W{is_signed & b[SRC_W-1]}}, b};
      prod  = ext_a * ext_b;
      unique case (mode)
         ACC_ADD: res = acc + prod;
         ACC_SUB: res = acc - prod;
         default: res = prod;
      endcase
   end
endmodule

// File: rtl/wmac_top.sv
module wmac_top
   import wmac_pkg::*;
#(
   parameter int VEC_W     = 128,
   parameter int NUM_SIZES = 3,
   localparam int HALF_W   = VEC_W / 2
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [31:0]       insn,
   input  logic [VEC_W-1:0]  src_a,
   input  logic [VEC_W-1:0]  src_b,
   input  logic [VEC_W-1:0]  acc_in,
   output logic              out_valid,
   output logic [VEC_W-1:0]  out_result,
   output logic              out_illegal,
   output logic              out_unsupported
);
   if (VEC_W != 128) begin : g_bad_width
      $error("wmac_top: VEC_W must be 128 to match the instruction lane layout");
   end
   if (NUM_SIZES != 3) begin : g_bad_sizes
      $error("wmac_top: NUM_SIZES must be 3");
   end

   dec_t dec;
   logic unused_fields;
   assign unused_fields = ^{insn[31], insn[28:24], insn[21:16], insn[11:0]};

   wmac_decode dec_i (
      .opcode (insn[15:12]),
      .u_bit  (insn[29]),
      .q_bit  (insn[30]),
      .size   (insn[23:22]),
      .dec    (dec)
   );

   logic [HALF_W-1:0] half_a;
   logic [HALF_W-1:0] half_b;
   assign half_a = dec.upper ? src_a[VEC_W-1:HALF_W] : src_a[HALF_W-1:0];
   assign half_b = dec.upper ? src_b[VEC_W-1:HALF_W] : src_b[HALF_W-1:0];

   logic [VEC_W-1:0] res_by_size [NUM_SIZES];

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      localparam int SW = 8 << s;
      localparam int DW = 2 * SW;
      localparam int NL = HALF_W / SW;
      for (genvar l = 0; l < NL; l++) begin : g_lane
         wmac_lane #(.SRC_W(SW)) lane_i (
            .a         (half_a[l*SW +: SW]),
            .b         (half_b[l*SW +: SW]),
            .acc       (acc_in[l*DW +: DW]),
            .is_signed (dec.is_signed),
            .mode      (dec.mode),
            .res       (res_by_size[s][l*DW +: DW])
         );
      end
   end

   logic [VEC_W-1:0] next_result;
   always_comb begin
      next_result = '0;
      if (dec.exec) begin
         unique case (dec.size)
            2'd0:    next_result = res_by_size[0];
            2'd1:    next_result = res_by_size[1];
            2'd2:    next_result = res_by_size[2];
            default: next_result = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid       <= 1'b0;
         out_result      <= '0;
         out_illegal     <= 1'b0;
         out_unsupported <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result      <= next_result;
            out_illegal     <= dec.illegal;
            out_unsupported <= dec.unsupp;
         end
      end
   end
endmodule

// File: rtl/wmac_chk.sv
module wmac_chk #(
   parameter int VEC_W = 128
)(
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [31:0]      insn,
   input logic             out_valid,
   input logic [VEC_W-1:0] out_result,
   input logic             out_illegal,
   input logic             out_unsupported
);
   assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   assert_hold_result_R8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_result) && $stable(out_illegal) && $stable(out_unsupported)));
   assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
      !(out_illegal && out_unsupported));
   assert_flagged_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (out_illegal || out_unsupported) |-> (out_result == '0));
   assert_op15_illegal_R2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && insn[15:12] == 4'd15) |=> out_illegal);
   assert_low_op_unsupported_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && insn[15:12] < 4'd8) |=> (out_unsupported && !out_illegal));
   assert_size3_illegal_R2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && insn[23:22] == 2'd3 &&
       (insn[15:12] == 4'd8 || insn[15:12] == 4'd10 || insn[15:12] == 4'd12)) |=> out_illegal);
endmodule

bind wmac_top wmac_chk #(.VEC_W(VEC_W)) chk_i (
   .clk             (clk),
   .rst             (rst),
   .in_valid        (in_valid),
   .insn            (insn),
   .out_valid       (out_valid),
   .out_result      (out_result),
   .out_illegal     (out_illegal),
   .out_unsupported (out_unsupported)
);

// File: tb/wmac_top_tb_top.sv
module wmac_top_tb_top;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [31:0]  insn = '0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic [127:0] acc_in = '0;
   logic         out_valid;
   logic [127:0] out_result;
   logic         out_illegal;
   logic         out_unsupported;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   wmac_top dut_i (
      .clk             (clk),
      .rst             (rst),
      .in_valid        (in_valid),
      .insn            (insn),
      .src_a           (src_a),
      .src_b           (src_b),
      .acc_in          (acc_in),
      .out_valid       (out_valid),
      .out_result      (out_result),
      .out_illegal     (out_illegal),
      .out_unsupported (out_unsupported)
   );

   task automatic check(input string tag, input logic [129:0] act, input logic [129:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_insn(input int op, input int u, input int q, input int sz);
      logic [31:0] w;
      w = {1'b0, q[0], u[0], 5'b01110, sz[1:0], 1'b1, 5'($urandom),
           op[3:0], 2'b00, 5'($urandom), 5'($urandom)};
      return w;
   endfunction

   // reference: {illegal, unsupported, result}
   function automatic logic [129:0] ref_model(input logic [31:0] w, input logic [127:0] a,
                                              input logic [127:0] b, input logic [127:0] d);
      int op, u, q, sz, ew, nl;
      logic [63:0] m1, m2, ea, eb, dl, p, r;
      logic [127:0] res;
      op = int'(w[15:12]); u = int'(w[29]); q = int'(w[30]); sz = int'(w[23:22]);
      if (op == 15) return {2'b10, 128'd0};
      if ((op == 8 || op == 10 || op == 12) && sz == 3) return {2'b10, 128'd0};
      if ((op == 9 || op == 11 || op == 13 || op == 14) && u == 1) return {2'b10, 128'd0};
      if (!(op == 8 || op == 10 || op == 12)) return {2'b01, 128'd0};
      ew = 8 << sz;
      nl = 64 / ew;
      m1 = (64'd1 << ew) - 64'd1;
      m2 = (2 * ew == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (2 * ew)) - 64'd1);
      res = '0;
      for (int i = 0; i < nl; i++) begin
         ea = 64'(a >> (q * 64 + i * ew)) & m1;
         eb = 64'(b >> (q * 64 + i * ew)) & m1;
         if (u == 0 && ea[ew-1]) ea = ea | ~m1;
         if (u == 0 && eb[ew-1]) eb = eb | ~m1;
         p  = (ea * eb) & m2;
         dl = 64'(d >> (i * 2 * ew)) & m2;
         if (op == 8)       r = (dl + p) & m2;
         else if (op == 10) r = (dl - p) & m2;
         else               r = p;
         res = res | (128'(r) << (i * 2 * ew));
      end
      return {2'b00, res};
   endfunction

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   task automatic run_one(input string tag, input logic [31:0] w, input logic [127:0] a,
                          input logic [127:0] b, input logic [127:0] d, input bit hold);
      logic [129:0] got;
      @(negedge clk);
      insn = w; src_a = a; src_b = b; acc_in = d; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      insn = ~w; src_a = ~a; src_b = ~b; acc_in = ~d;
      check({tag, " valid R8"}, {129'd0, out_valid}, {129'd0, 1'b1});
      got = {out_illegal, out_unsupported, out_result};
      check(tag, got, ref_model(w, a, b, d));
      if (hold) begin
         @(negedge clk);
         check("R8 pulse", {129'd0, out_valid}, 130'd0);
         check("R8 hold", {out_illegal, out_unsupported, out_result}, got);
      end
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset", {out_valid, out_illegal, out_unsupported, out_result, 1'b0}, 130'd0);
      rst = 1'b0;

      // full sweep of opcode, U, Q and size
      for (int op = 0; op < 16; op++)
         for (int u = 0; u < 2; u++)
            for (int q = 0; q < 2; q++)
               for (int sz = 0; sz < 4; sz++)
                  for (int k = 0; k < 4; k++) begin
                     string tag;
                     if (op == 15 || ((op == 8 || op == 10 || op == 12) && sz == 3) ||
                         ((op == 9 || op == 11 || op == 13 || op == 14) && u == 1))
                        tag = "R2 illegal";
                     else if (!(op == 8 || op == 10 || op == 12))
                        tag = "R3 unsupported";
                     else
                        tag = "R1 R4 R5 R6 R7 sweep";
                     run_one(tag, mk_insn(op, u, q, sz), rnd128(), rnd128(), rnd128(), k == 0);
                  end

      // R4: extension of all-ones elements
      run_one("R4 signed", mk_insn(12, 0, 0, 0), {128{1'b1}}, {128{1'b1}}, '0, 1'b0);
      check("R4 signed lane", {114'd0, out_result[15:0]}, 130'h0001);
      run_one("R4 unsigned", mk_insn(12, 1, 0, 0), {128{1'b1}}, {128{1'b1}}, '0, 1'b0);
      check("R4 unsigned lane", {114'd0, out_result[15:0]}, 130'hFE01);
      run_one("R4 signed 32", mk_insn(12, 0, 0, 2), {4{32'h8000_0000}}, {4{32'h8000_0000}}, '0, 1'b0);
      check("R4 min squared", {66'd0, out_result[63:0]}, {66'd0, 64'h4000_0000_0000_0000});

      // R5: upper half selection
      run_one("R5 upper", mk_insn(12, 1, 1, 1), {16'd3, 112'd0}, {16'd5, 112'd0}, '0, 1'b0);
      check("R5 upper lane3", {98'd0, out_result[127:96]}, 130'd15);
      run_one("R5 lower", mk_insn(12, 1, 0, 1), {16'd3, 112'd0}, {16'd5, 112'd0}, '0, 1'b0);
      check("R5 lower zero", {2'b00, out_result}, 130'd0);

      // R7: wrap without carry across lanes
      run_one("R7 add wrap", mk_insn(8, 1, 0, 0), 128'd1, 128'd1,
              {112'h0, 16'hFFFF}, 1'b0);
      check("R7 add wrap lanes", {2'b00, out_result}, {2'b00, 112'd0, 16'd0});
      run_one("R7 sub wrap", mk_insn(10, 1, 0, 1), 128'd1, 128'd1, 128'd0, 1'b0);
      check("R7 sub wrap lanes", {2'b00, out_result}, {2'b00, 96'd0, 32'hFFFF_FFFF});
      run_one("R1 R6 sub 64", mk_insn(10, 0, 0, 2), {64'd0, 32'd2, 32'd3}, {64'd0, 32'd4, 32'hFFFF_FFFF},
              {64'd100, 64'd100}, 1'b0);
      check("R1 R6 sub 64 lanes", {2'b00, out_result}, {2'b00, 64'd92, 64'd103});

      // R9: reset mid-run clears held outputs
      run_one("R9 preload", mk_insn(12, 1, 0, 0), rnd128() | 128'd1, rnd128() | 128'd1, '0, 1'b0);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check("R9 mid reset", {out_valid, out_illegal, out_unsupported, out_result, 1'b0}, 130'd0);
      rst = 1'b0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule